// File: doc/BRIEF.md
# Pipelined Scan Register Access Chain

This block connects a serial debug shift path to a parallel register bus. A debug host shifts a 40-bit frame through it. The frame carries a data field, a register address and a direction flag. When the update strobe arrives, the block issues one bus access that the frame decodes to: a write of the data field, or a read of the addressed location.

Reads are pipelined one scan deep. The bus answer for a read is held in a result register. The capture strobe of the following scan loads that result into the data field, and it leaves the chain serially. The value shifted out of a scan therefore always belongs to the read carried by an earlier scan.

A host draining a location that advances on every read (a trace data port, say) repeats that address for each frame. On the last frame it switches to a location without side effects, so that the final update does not consume one more entry. The TAP state machine and the instruction decode that select this chain are outside the block.

Top module: `sra_scan_access`

## Requirements
- R1: After a synchronous reset, `bus_rd`, `bus_wr` and `scan_tdo` are 0, and the result register holds 0, so the first scan shifts out a zero data field.
- R2: Serial bits are taken in LSB first. The first 32 bits shifted in form the data field, the next 7 the address, and the 40th the direction flag (1 = write, 0 = read). `bus_rd` and `bus_wr` are never high together.
- R3: An update after a frame with flag 0 raises `bus_rd` for exactly one cycle, in the cycle after the update, with `bus_addr` set to the frame's address and no write.
- R4: Read data from the access in scan N is shifted out LSB first on `scan_tdo` in the data field of scan N+1. This needs at least three clock cycles between that update and the next capture.
- R5: An update after a frame with flag 1 raises `bus_wr` for exactly one cycle, in the cycle after the update, with the frame's address and data. The write therefore takes effect during the scan that carries it.
- R6: An update that is not preceded by at least one shift cycle since the last update issues no bus access.
- R7: A shift of more or fewer than 40 bits still yields exactly one access at update. That access is decoded from the current register contents. Capture loads the result into bits 31:0 and clears bits 39:32, and each shift moves the register one place toward bit 0.
- R8: A bulk read that repeats address 4 and ends on address 0 causes exactly one read per update. The results of the address-4 reads come out in order in the following scans, and the final address-0 read consumes no extra entry of the address-4 location.
- R9: The capture strobe loads only the most recent read result. A write access leaves the result register unchanged, so the scan after a write shifts out the same value as the scan before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_shift_en | input | 1 | Shift the chain one place on this cycle |
| scan_capture | input | 1 | Load the last read result into the data field |
| scan_update | input | 1 | Issue the access that the frame decodes to |
| scan_tdi | input | 1 | Serial data in |
| scan_tdo | output | 1 | Serial data out (chain bit 0) |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_addr | output | 7 | Access address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid the cycle after `bus_rd` |

## Verification
The bench sends a write-then-read-back pattern to plain registers. This separates the one-scan read pipeline from a zero-latency readout, and it shows that a write leaves the result register alone. A bulk drain of an auto-advancing location, ending on a side-effect-free address, checks the ordering of the results. A later read of that location checks that the drain consumed exactly the intended number of entries. Update-without-shift, a 41-bit shift and an 8-bit shift check, respectively, the suppression of stray accesses and the decode of whatever the register holds.

// File: rtl/sra_pkg.sv
package sra_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  function automatic acc_kind_e decode_access(input logic armed, input logic dir_flag);
    if (!armed) return ACC_NONE;
    return dir_flag ? ACC_WRITE : ACC_READ;
  endfunction
endpackage

// File: rtl/sra_shift_reg.sv
module sra_shift_reg #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7,
  localparam int FRAME_W = DATA_W + ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic               capture,
  input  logic               update,
  input  logic               tdi,
  input  logic [DATA_W-1:0]  load_data,
  output logic               tdo,
  output logic [FRAME_W-1:0] frame,
  output logic               armed
);
  localparam int HDR_W = ADDR_W + 1;

  logic [FRAME_W-1:0] sr_q;
  logic               armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q    <= '0;
      armed_q <= 1'b0;
    end else begin
      if (capture)
        sr_q <= {{HDR_W{1'b0}}, load_data};
      else if (shift_en)
        sr_q <= {tdi, sr_q[FRAME_W-1:1]};
      if (shift_en)
        armed_q <= 1'b1;
      else if (update)
        armed_q <= 1'b0;
    end
  end

  assign tdo   = sr_q[0];
  assign frame = sr_q;
  assign armed = armed_q;
endmodule

// File: rtl/sra_bus_issue.sv
module sra_bus_issue
  import sra_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7,
  localparam int FRAME_W = DATA_W + ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               update,
  input  logic               armed,
  input  logic [FRAME_W-1:0] frame,
  output logic               bus_rd,
  output logic               bus_wr,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata
);
  acc_kind_e kind;

  always_comb begin
    kind = ACC_NONE;
    if (update) kind = decode_access(armed, frame[FRAME_W-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      bus_rd <= (kind == ACC_READ);
      bus_wr <= (kind == ACC_WRITE);
      if (kind != ACC_NONE) begin
        bus_addr  <= frame[DATA_W +: ADDR_W];
        bus_wdata <= frame[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/sra_read_latch.sv
module sra_read_latch #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] result
);
  logic              rd_wait_q;
  logic [DATA_W-1:0] result_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_wait_q <= 1'b0;
      result_q  <= '0;
    end else begin
      rd_wait_q <= bus_rd;
      if (rd_wait_q) result_q <= bus_rdata;
    end
  end

  assign result = result_q;
endmodule

// File: rtl/sra_scan_access.sv
module sra_scan_access #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_shift_en,
  input  logic              scan_capture,
  input  logic              scan_update,
  input  logic              scan_tdi,
  output logic              scan_tdo,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int FRAME_W = DATA_W + ADDR_W + 1;

  logic [FRAME_W-1:0] frame;
  logic               armed;
  logic [DATA_W-1:0]  result;

  sra_shift_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(scan_shift_en), .capture(scan_capture),
    .update(scan_update), .tdi(scan_tdi), .load_data(result),
    .tdo(scan_tdo), .frame(frame), .armed(armed)
  );

  sra_bus_issue #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_issue (
    .clk(clk), .rst(rst), .update(scan_update), .armed(armed), .frame(frame),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
  );

  sra_read_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .result(result)
  );
endmodule

// File: rtl/sra_scan_access_chk.sv
module sra_scan_access_chk (
  input logic clk,
  input logic rst,
  input logic scan_shift_en,
  input logic scan_update,
  input logic bus_rd,
  input logic bus_wr
);
  logic seen_shift;

  always_ff @(posedge clk) begin
    if (rst) seen_shift <= 1'b0;
    else if (scan_shift_en) seen_shift <= 1'b1;
    else if (scan_update) seen_shift <= 1'b0;
  end

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  assert_rd_single_R3: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> !bus_rd);

  assert_wr_single_R5: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> !bus_wr);

  assert_strobe_after_update_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> $past(scan_update));

  assert_no_unarmed_access_R6: assert property (@(posedge clk) disable iff (rst)
    (scan_update && !scan_shift_en && !seen_shift) |=> !(bus_rd || bus_wr));
endmodule

bind sra_scan_access sra_scan_access_chk u_chk (
  .clk(clk), .rst(rst), .scan_shift_en(scan_shift_en), .scan_update(scan_update),
  .bus_rd(bus_rd), .bus_wr(bus_wr)
);

// File: tb/sra_scan_access_tb.sv
module sra_scan_access_tb;
  localparam logic [31:0] ID_VAL    = 32'h1D0C_0001;
  localparam logic [31:0] FIFO_BASE = 32'hA000_0000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic scan_shift_en = 1'b0, scan_capture = 1'b0, scan_update = 1'b0, scan_tdi = 1'b0;
  logic scan_tdo, bus_rd, bus_wr;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  sra_scan_access u_dut (
    .clk(clk), .rst(rst), .scan_shift_en(scan_shift_en), .scan_capture(scan_capture),
    .scan_update(scan_update), .scan_tdi(scan_tdi), .scan_tdo(scan_tdo),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  // Register file on the bus: address 0 fixed id, address 4 auto-advancing port.
  logic [31:0] regs [0:127];
  logic [31:0] rdata_q, last_wr_data;
  logic [6:0]  last_rd_addr, last_wr_addr;
  int unsigned fifo_ptr, rd_cnt, wr_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0; fifo_ptr <= 0; rd_cnt <= 0; wr_cnt <= 0;
      last_rd_addr <= '0; last_wr_addr <= '0; last_wr_data <= '0;
    end else begin
      if (bus_wr) begin
        wr_cnt <= wr_cnt + 1;
        last_wr_addr <= bus_addr;
        last_wr_data <= bus_wdata;
        if (bus_addr != 7'd0 && bus_addr != 7'd4) regs[bus_addr] <= bus_wdata;
      end
      if (bus_rd) begin
        rd_cnt <= rd_cnt + 1;
        last_rd_addr <= bus_addr;
        if (bus_addr == 7'd0) rdata_q <= ID_VAL;
        else if (bus_addr == 7'd4) begin
          rdata_q <= FIFO_BASE + fifo_ptr;
          fifo_ptr <= fifo_ptr + 1;
        end else rdata_q <= regs[bus_addr];
      end
    end
  end
  assign bus_rdata = rdata_q;

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard: driver pushes the expected data field, monitor compares.
  logic [31:0] exp_q[$];
  logic [31:0] scan_got;
  string       scan_req;
  event        scan_done;

  initial begin
    forever begin
      @(scan_done);
      if (exp_q.size() != 0) begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(scan_got == e, scan_req, scan_got, e);
      end
    end
  end

  // Expected-state model kept by the driver.
  logic [31:0] shadow [0:127];
  logic [31:0] last_read_exp = '0;
  int unsigned exp_fifo = 0;

  task automatic run_scan(input logic [39:0] fr, input int nbits, input int lead,
                          input bit cmp, input string req);
    logic [31:0] got;
    got = '0;
    if (cmp) exp_q.push_back(last_read_exp);
    @(negedge clk) scan_capture = 1'b1;
    @(negedge clk) scan_capture = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      int idx;
      idx = i - lead;
      scan_shift_en = 1'b1;
      scan_tdi = (idx >= 0 && idx < 40) ? fr[idx] : 1'b0;
      if (i < 32) got[i] = scan_tdo;
      @(negedge clk);
    end
    scan_shift_en = 1'b0;
    scan_update = 1'b1;
    @(negedge clk) scan_update = 1'b0;
    scan_got = got;
    scan_req = req;
    if (cmp) ->scan_done;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_access(input logic wr, input logic [6:0] a, input logic [31:0] d,
                           input string req);
    int unsigned rd0, wr0;
    rd0 = rd_cnt; wr0 = wr_cnt;
    run_scan({wr, a, d}, 40, 0, 1'b1, req);
    if (wr) begin
      check(wr_cnt == wr0 + 1, "R5 write strobe count", wr_cnt - wr0, 1);
      check(rd_cnt == rd0, "R2 no read on write", rd_cnt - rd0, 0);
      check(last_wr_addr == a && last_wr_data == d, "R5 write addr/data",
            {last_wr_addr, last_wr_data[24:0]}, {a, d[24:0]});
      if (a != 7'd0 && a != 7'd4) shadow[a] = d;
    end else begin
      check(rd_cnt == rd0 + 1, "R3 read strobe count", rd_cnt - rd0, 1);
      check(wr_cnt == wr0, "R3 no write on read", wr_cnt - wr0, 0);
      check(last_rd_addr == a, "R3 read addr", {25'd0, last_rd_addr}, {25'd0, a});
      if (a == 7'd0) last_read_exp = ID_VAL;
      else if (a == 7'd4) begin
        last_read_exp = FIFO_BASE + exp_fifo;
        exp_fifo++;
      end else last_read_exp = shadow[a];
    end
  endtask

  initial begin
    int unsigned rd0, wr0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(bus_rd == 1'b0 && bus_wr == 1'b0, "R1 strobes idle after reset",
          {30'd0, bus_rd, bus_wr}, 0);
    check(scan_tdo == 1'b0, "R1 tdo low after reset", {31'd0, scan_tdo}, 0);

    // R1/R2/R5: first scan writes and shifts out a zero result.
    do_access(1'b1, 7'd10, 32'hCAFE_0010, "R1 first scan data zero");
    do_access(1'b0, 7'd10, 32'h0, "R9 no read yet");
    do_access(1'b1, 7'd11, 32'h1234_5678, "R4 read of 10 in next scan");
    do_access(1'b0, 7'd11, 32'h0, "R9 write kept result");
    do_access(1'b1, 7'd12, 32'h0F0F_F0F0, "R4 read of 11 in next scan");

    // R8 bulk drain: address 4 repeated, last frame on address 0.
    do_access(1'b0, 7'd4, 32'h0, "R8 bulk frame 0");
    do_access(1'b0, 7'd4, 32'h0, "R8 bulk frame 1");
    do_access(1'b0, 7'd4, 32'h0, "R8 bulk frame 2");
    do_access(1'b0, 7'd0, 32'h0, "R8 bulk last frame");
    do_access(1'b1, 7'd13, 32'h0000_0013, "R8 id after drain");
    do_access(1'b0, 7'd4, 32'h0, "R8 next entry");
    do_access(1'b1, 7'd14, 32'h0000_0014, "R8 no extra entry consumed");

    // R6: update with no shift.
    rd0 = rd_cnt; wr0 = wr_cnt;
    run_scan(40'h0, 0, 0, 1'b0, "R6");
    check(rd_cnt == rd0 && wr_cnt == wr0, "R6 no access without shift",
          (rd_cnt - rd0) + (wr_cnt - wr0), 0);

    // R7: 41-bit shift, one junk bit first, frame still aligned.
    rd0 = rd_cnt; wr0 = wr_cnt;
    run_scan({1'b1, 7'd20, 32'h5555_AAAA}, 41, 1, 1'b1, "R7 long shift data out");
    check(wr_cnt == wr0 + 1 && rd_cnt == rd0, "R7 long shift single write",
          wr_cnt - wr0, 1);
    check(last_wr_addr == 7'd20 && last_wr_data == 32'h5555_AAAA, "R7 long shift decode",
          last_wr_data, 32'h5555_AAAA);

    // R7: 8-bit shift of 0x85 after capture: write to 5 of {00, result[31:8]}.
    rd0 = rd_cnt; wr0 = wr_cnt;
    run_scan(40'h85, 8, 0, 1'b0, "R7");
    check(wr_cnt == wr0 + 1 && rd_cnt == rd0, "R7 short shift single write",
          wr_cnt - wr0, 1);
    check(last_wr_addr == 7'd5, "R7 short shift addr", {25'd0, last_wr_addr}, 32'd5);
    check(last_wr_data == {8'h00, last_read_exp[31:8]}, "R7 short shift data",
          last_wr_data, {8'h00, last_read_exp[31:8]});

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule